// File: doc/BRIEF.md
# Multi-Ratio CIC Decimation Filter

This block turns a one-bit oversampled bitstream into 16-bit samples at a lower rate. The filter is a three-stage cascaded integrator-comb structure. The integrator stages accumulate on every enabled clock. A rate counter produces a one-cycle decimation pulse once per ratio period, and only that pulse advances the comb stages. Each comb stage differences over one decimated sample.

The decimation ratio is read from a 7-bit input at runtime. The accepted values are 8, 16, 32 and 64, and any other value is treated as 16. When the effective ratio changes, the rate counter starts again from zero. All internal arithmetic is 16-bit two's complement and wraps on overflow. A constant stream of ones therefore settles at the cube of the ratio, reduced modulo 2^16. The bit arriving from the modulator enters the first integrator as +1 for a one and as 0 for a zero.

Top module: `cic_decim_top`

## Requirements
- R1: A synchronous reset clears every integrator, comb delay, rate counter and output register. On the cycle after reset, `sample_o` is 0 and `valid_o` is 0, and the effective ratio returns to 16.
- R2: While enabled at a steady ratio R, `valid_o` rises exactly once every R cycles, and each time it stays high for a single cycle.
- R3: A ratio input of 8, 16, 32 or 64 selects that ratio. Every other ratio value (for example 0 or 20) behaves exactly like 16, both in valid spacing and in gain.
- R4: An input bit of 1 adds +1 to the first integrator and a bit of 0 adds nothing, so an all-zero stream produces 0 on every output sample.
- R5: With a constant all-ones input, the settled output equals R^3 mod 2^16: 512 for R=8, 4096 for R=16, 0x8000 for R=32 and 0x0000 for R=64.
- R6: An alternating 1/0 input (half density) settles at R^3/2 mod 2^16: 256 for R=8 and 2048 for R=16.
- R7: While `en` is low, the integrators and the rate counter hold their values, `valid_o` stays low and `sample_o` does not change. When `en` returns, the interval between valids grows by exactly the number of disabled cycles.
- R8: A change of the effective ratio restarts the rate counter at zero. The first valid after the change is seen R+1 rising edges later, counting the edge that samples the new ratio, and no decimation pulse fires on that edge.
- R9: `valid_o` is high in the cycle after a decimation pulse, and `sample_o` changes only in a cycle where `valid_o` is high (outside reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Enables integration and rate counting |
| bit_i | input | 1 | Oversampled bitstream bit |
| ratio_i | input | 7 | Requested decimation ratio |
| sample_o | output | 16 | Decimated sample, two's complement |
| valid_o | output | 1 | One-cycle strobe marking a new sample |

## Verification
The bound checker checks on every cycle the properties that concern timing only. These are: valids never fall on adjacent cycles, a valid always follows a decimation pulse, the sample holds while disabled and between valids, the rate counter stays below the current ratio, and the counter returns to zero when the ratio changes. Two groups of behaviour can be shown only by the bench scenarios. The first is the numeric behaviour: DC gain at each ratio including wrap-around, the half-density result, the zero stream, and the remapping of illegal ratios. The second is the exact R+1 latency after a ratio change and the stretched interval around an enable gap.

// File: rtl/cic_pkg.sv
package cic_pkg;

    localparam int unsigned CIC_DATA_W  = 16;
    localparam int unsigned CIC_RATIO_W = 7;
    localparam int unsigned CIC_STAGES  = 3;

    // Effective decimation ratio, kept compact in state
    typedef enum logic [1:0] {
        RATE_8  = 2'd0,
        RATE_16 = 2'd1,
        RATE_32 = 2'd2,
        RATE_64 = 2'd3
    } rate_sel_e;

endpackage

// File: rtl/cic_rate_ctrl.sv
module cic_rate_ctrl
    import cic_pkg::*;
#(
    parameter int unsigned RW = CIC_RATIO_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [RW-1:0] ratio_i,
    output logic [RW-1:0] rate_o,
    output logic [RW-1:0] cnt_o,
    output logic          strobe_o
);

    typedef struct packed {
        rate_sel_e     sel;
        logic [RW-1:0] cnt;
    } state_t;

    state_t    q, d;
    rate_sel_e sel_in;
    logic      chg;
    logic [RW-1:0] rate_cur;
    logic [RW-1:0] last_cnt;

    // Map the request onto a legal ratio; anything else becomes 16
    always_comb begin
        case (ratio_i)
            RW'(8):  sel_in = RATE_8;
            RW'(16): sel_in = RATE_16;
            RW'(32): sel_in = RATE_32;
            RW'(64): sel_in = RATE_64;
            default: sel_in = RATE_16;
        endcase
    end

    always_comb begin
        case (q.sel)
            RATE_8:  rate_cur = RW'(8);
            RATE_16: rate_cur = RW'(16);
            RATE_32: rate_cur = RW'(32);
            default: rate_cur = RW'(64);
        endcase
    end

    assign last_cnt = rate_cur - RW'(1);
    assign chg      = (sel_in != q.sel);
    assign strobe_o = en && !chg && (q.cnt == last_cnt);

    always_comb begin
        d     = q;
        d.sel = sel_in;
        if (chg) begin
            d.cnt = '0;
        end else if (en) begin
            if (q.cnt == last_cnt) begin
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + RW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.sel <= RATE_16;
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign rate_o = rate_cur;
    assign cnt_o  = q.cnt;

endmodule

// File: rtl/cic_integ_chain.sv
module cic_integ_chain
    import cic_pkg::*;
#(
    parameter int unsigned W = CIC_DATA_W,
    parameter int unsigned N = CIC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         bit_i,
    output logic [W-1:0] acc_o
);

    typedef struct packed {
        logic [N-1:0][W-1:0] acc;
    } state_t;

    state_t q, d;
    logic [W-1:0] x_w;

    // A one enters as +1, a zero as 0
    assign x_w = {{(W-1){1'b0}}, bit_i};

    always_comb begin
        d = q;
        if (en) begin
            d.acc[0] = q.acc[0] + x_w;
            for (int k = 1; k < int'(N); k++) begin
                d.acc[k] = q.acc[k] + q.acc[k-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign acc_o = q.acc[N-1];

endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain
    import cic_pkg::*;
#(
    parameter int unsigned W = CIC_DATA_W,
    parameter int unsigned N = CIC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         strobe_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] sample_o,
    output logic         valid_o
);

    typedef struct packed {
        logic [N-1:0][W-1:0] dly;
        logic [W-1:0]        sample;
        logic                valid;
    } state_t;

    state_t q, d;
    logic [N:0][W-1:0] tap;

    assign tap[0] = din_i;

    for (genvar g = 0; g < int'(N); g++) begin : g_stage
        assign tap[g+1] = tap[g] - q.dly[g];
    end

    always_comb begin
        d       = q;
        d.valid = strobe_i;
        if (strobe_i) begin
            for (int k = 0; k < int'(N); k++) begin
                d.dly[k] = tap[k];
            end
            d.sample = tap[N];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sample_o = q.sample;
    assign valid_o  = q.valid;

endmodule

// File: rtl/cic_decim_top.sv
module cic_decim_top
    import cic_pkg::*;
#(
    parameter int unsigned DATA_W  = CIC_DATA_W,
    parameter int unsigned RATIO_W = CIC_RATIO_W,
    parameter int unsigned STAGES  = CIC_STAGES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               bit_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic [DATA_W-1:0]  sample_o,
    output logic               valid_o
);

    logic [RATIO_W-1:0] rate_w;
    logic [RATIO_W-1:0] cnt_w;
    logic               strobe_w;
    logic [DATA_W-1:0]  integ_w;

    cic_rate_ctrl #(
        .RW (RATIO_W)
    ) u_rate (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .ratio_i  (ratio_i),
        .rate_o   (rate_w),
        .cnt_o    (cnt_w),
        .strobe_o (strobe_w)
    );

    cic_integ_chain #(
        .W (DATA_W),
        .N (STAGES)
    ) u_integ (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .bit_i (bit_i),
        .acc_o (integ_w)
    );

    cic_comb_chain #(
        .W (DATA_W),
        .N (STAGES)
    ) u_comb (
        .clk      (clk),
        .rst      (rst),
        .strobe_i (strobe_w),
        .din_i    (integ_w),
        .sample_o (sample_o),
        .valid_o  (valid_o)
    );

endmodule

// File: rtl/cic_decim_chk.sv
module cic_decim_chk #(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned RATIO_W = 7
) (
    input logic               clk,
    input logic               rst,
    input logic               en,
    input logic               valid_o,
    input logic [DATA_W-1:0]  sample_o,
    input logic               strobe,
    input logic [RATIO_W-1:0] rate,
    input logic [RATIO_W-1:0] cnt
);

    // R2
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt < rate);

    // R7
    valid_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !valid_o);

    // R7
    hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(sample_o));

    // R8
    restart_on_change_chk: assert property (@(posedge clk) disable iff (rst)
        (rate != $past(rate)) |-> (cnt == '0));

    // R9
    valid_after_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $past(strobe));

    // R9
    sample_moves_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sample_o) && !$past(rst)) |-> valid_o);

endmodule

bind cic_decim_top cic_decim_chk #(
    .DATA_W  (DATA_W),
    .RATIO_W (RATIO_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .valid_o  (valid_o),
    .sample_o (sample_o),
    .strobe   (strobe_w),
    .rate     (rate_w),
    .cnt      (cnt_w)
);

// File: tb/cic_decim_top_tb_top.sv
module cic_decim_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PAUSE      = 40;

    typedef struct {
        int          gap;
        logic        chk;
        logic [15:0] val;
        string       req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        bit_i;
    logic [6:0]  ratio_i = 7'd16;
    logic [15:0] sample_o;
    logic        valid_o;

    logic alt_mode = 1'b0;
    logic const_bit = 1'b0;
    logic tgl = 1'b0;

    item_t exp_q[$];
    int    cyc = 0;
    int    last_cyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    assign bit_i = alt_mode ? tgl : const_bit;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) tgl <= ~tgl;

    cic_decim_top dut_i (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .bit_i    (bit_i),
        .ratio_i  (ratio_i),
        .sample_o (sample_o),
        .valid_o  (valid_o)
    );

    task automatic check(input string req, input bit ok, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, expv, expv);
        end
    endtask

    // Monitor: pops one expected item per valid sample
    always @(negedge clk) begin
        if (!rst && valid_o) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected valid", 1'b0, 1, 0);
                last_cyc = cyc;
            end else begin
                item_t it;
                int gap;
                it  = exp_q.pop_front();
                gap = cyc - last_cyc;
                last_cyc = cyc;
                if (it.gap != 0) check({it.req, " gap"}, gap == it.gap, gap, it.gap);
                if (it.chk) check({it.req, " value"}, sample_o == it.val, int'(sample_o), int'(it.val));
            end
        end
    end

    task automatic wait_empty();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // Driver: reset, configure, push expectations, run
    task automatic run_seg(input string req, input logic alt, input logic one,
                           input int r_in, input int r_eff, input int n,
                           input int first_chk, input logic [15:0] expv,
                           input int pause_after);
        @(negedge clk);
        rst = 1'b1; en = 1'b1; ratio_i = 7'(r_in);
        alt_mode = alt; const_bit = one;
        @(negedge clk);
        rst = 1'b0;
        // R1: outputs cleared after reset
        check("R1 sample after reset", sample_o == 16'd0, int'(sample_o), 0);
        check("R1 valid after reset", valid_o == 1'b0, int'(valid_o), 0);
        for (int i = 0; i < n; i++) begin
            item_t it;
            it.gap = (i == 0) ? 0 : ((i == pause_after + 1) ? r_eff + PAUSE : r_eff);
            it.chk = (i >= first_chk);
            it.val = expv;
            it.req = (i == pause_after + 1) ? "R7" : req;
            exp_q.push_back(it);
        end
        if (pause_after >= 0) begin
            logic [15:0] held;
            while (exp_q.size() > n - 1 - pause_after) @(negedge clk);
            en = 1'b0;
            held = sample_o;
            for (int k = 0; k < PAUSE; k++) begin
                @(negedge clk);
                // R7: frozen output while disabled
                check("R7 hold", sample_o == held, int'(sample_o), int'(held));
                check("R7 no valid", valid_o == 1'b0, int'(valid_o), 0);
            end
            en = 1'b1;
        end
        wait_empty();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 state straight out of reset
        run_seg("R5 ones r16", 1'b0, 1'b1, 16, 16, 8, 4, 16'd4096, -1);
        run_seg("R5 ones r8", 1'b0, 1'b1, 8, 8, 8, 4, 16'd512, -1);
        run_seg("R5 ones r32", 1'b0, 1'b1, 32, 32, 8, 4, 16'h8000, -1);
        run_seg("R5 ones r64 wrap", 1'b0, 1'b1, 64, 64, 8, 4, 16'h0000, -1);
        run_seg("R4 zeros", 1'b0, 1'b0, 16, 16, 6, 0, 16'd0, -1);
        run_seg("R6 alt r16", 1'b1, 1'b0, 16, 16, 8, 4, 16'd2048, -1);
        run_seg("R6 alt r8", 1'b1, 1'b0, 8, 8, 8, 4, 16'd256, -1);
        run_seg("R3 illegal 20", 1'b0, 1'b1, 20, 16, 8, 4, 16'd4096, -1);
        run_seg("R3 illegal 0", 1'b0, 1'b1, 0, 16, 7, 4, 16'd4096, -1);
        run_seg("R7 ones pause", 1'b0, 1'b1, 16, 16, 9, 4, 16'd4096, 5);

        // R8: ratio change mid-stream restarts the counter
        begin
            int c0;
            item_t it;
            @(negedge clk);
            rst = 1'b1; en = 1'b1; ratio_i = 7'd16; alt_mode = 1'b0; const_bit = 1'b1;
            @(negedge clk);
            rst = 1'b0;
            it.chk = 1'b0; it.val = '0; it.req = "R8";
            it.gap = 0;  exp_q.push_back(it);
            it.gap = 16; exp_q.push_back(it);
            while (exp_q.size() != 0) @(negedge clk);
            it.gap = 0; exp_q.push_back(it);
            it.gap = 8; exp_q.push_back(it);
            it.gap = 8; exp_q.push_back(it);
            @(negedge clk);
            ratio_i = 7'd8;
            c0 = cyc;
            while (exp_q.size() > 2) @(negedge clk);
            check("R8 first valid latency", (last_cyc - c0) == 9, last_cyc - c0, 9);
            wait_empty();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule